// File: doc/BRIEF.md
# Flash Chip-Select Address Window Decoder

This block sits between a host bus and a serial flash engine. Each chip-select owns one segment register. That register describes the part of the host address space that maps onto the chip. For every host request the block finds the chip-select whose window contains the address and reports the offset of the address inside that window. If no enabled window contains the address, it reports an error.

Two segment encodings exist, and the parameter `FINE` picks one when the block is built. The coarse encoding works in 8 MB units with absolute start and exclusive end addresses. The fine encoding works in 1 MB units: its fields are offsets from a fixed region base, its end field names the last block inclusively, and a zero end field turns the window off.

A shared configuration word holds a 2-bit device-type field and a write-permission bit for each chip-select. A host write that lands in a window whose permission bit is clear is refused with the error response. Software programs the registers through a simple word-wide port.

Top module: `fcs_addr_decode`

## Requirements
- R1: After reset every register reads 0, `rsp_valid` is 0, and any lookup returns the error response because no window is open.
- R2: Coarse encoding (`FINE`=0): a window covers the absolute addresses from bits [23:16] times 8 MB up to, but not including, bits [31:24] times 8 MB. A window whose end is not above its start matches nothing.
- R3: Fine encoding (`FINE`=1): a window starts at `FINE_BASE` plus bits [11:4] times 1 MB. It ends with the 1 MB block at `FINE_BASE` plus bits [27:20] times 1 MB, and that block is included.
- R4: Fine encoding: a segment whose end field (bits [27:20]) is 0 matches no address, whatever its start field holds.
- R5: When several windows contain the address, the response names the lowest-numbered chip-select.
- R6: On a hit, `rsp_offset` equals the host address minus the start address of the selected window.
- R7: A lookup that hits no window returns `rsp_err`=1 with `rsp_cs`=0 and `rsp_offset`=0.
- R8: A write lookup (`req_write`=1) whose selected chip has its permission bit (configuration bit 16+n) clear returns the error response. A read lookup ignores that bit.
- R9: Register map on `reg_addr`:
  - The configuration word is at 0x00. The type field of chip n is bits [2n+1:2n]; the value 2 denotes serial-flash type. The permission bit of chip n is bit 16+n.
  - The segment register of chip n is at 0x30+4n.
  - Only defined bits are stored. For segments these are [31:16] in coarse mode and [27:20] and [11:4] in fine mode.
  - Other offsets read 0 and ignore writes.
- R10: A lookup presented in one cycle is answered in the next cycle, and `rsp_valid` follows `req_valid` with one cycle of delay.
- R11: A register write and a lookup in the same cycle: the lookup sees the old register value, and the new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Host lookup request |
| req_write | input | 1 | Host request is a write |
| req_addr | input | 32 | Host byte address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_err | output | 1 | No enabled window hit, or write not permitted |
| rsp_cs | output | $clog2(NUM_CS) | Selected chip-select |
| rsp_offset | output | 32 | Offset of the address inside the selected window |

## Verification
The bench probes both window edges. In coarse mode the end address must miss; a design that treats the end as inclusive would claim one byte too many. In fine mode the whole last 1 MB block must hit; an exclusive end would drop it. A segment with a start field but a zero end field must stay closed; otherwise a disabled chip would answer. Overlapping windows check that the lowest index wins; a reversed priority encoder would name the wrong chip. A register write in the same cycle as a lookup checks that the lookup uses the old value; a design that forwards the new value would change answers one cycle early. Write lookups with permission bits clear and then set check that a read never depends on that bit.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned RAW       = 8;
  localparam logic [RAW-1:0] CFG_OFS = 8'h00;
  localparam logic [RAW-1:0] SEG_OFS = 8'h30;
  localparam int unsigned WE_LSB    = 16;
  localparam int unsigned TYPE_W    = 2;
  localparam logic [31:0] COARSE_MASK = 32'hFFFF_0000;
  localparam logic [31:0] FINE_MASK   = 32'h0FF0_0FF0;
  localparam int unsigned COARSE_SH = 23;
  localparam int unsigned FINE_SH   = 20;

  // decoded window: half-open range [lo, hi) on AW+1 bits
  typedef struct packed {
    logic          en;
    logic [AW:0]   lo;
    logic [AW:0]   hi;
  } win_t;
endpackage

// File: rtl/fcs_regs.sv
`timescale 1ns/1ps
module fcs_regs
  import fcs_pkg::*;
#(
  parameter int unsigned NUM_CS = 3,
  parameter bit          FINE   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RAW-1:0]       addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_CS*32-1:0] seg_flat,
  output logic [NUM_CS-1:0]    we_bits
);
  localparam logic [31:0] SEG_MASK = FINE ? FINE_MASK : COARSE_MASK;
  localparam int unsigned TW       = TYPE_W * NUM_CS;

  logic [TW-1:0]     type_q, type_d;
  logic [NUM_CS-1:0] we_q, we_d;
  logic              cfg_en;
  logic [31:0]       cfg_word;
  logic [31:0]       seg_q [NUM_CS];

  // configuration word
  always_comb begin
    cfg_en = wr_en && (addr == CFG_OFS);
    type_d = wdata[TW-1:0];
    we_d   = wdata[WE_LSB +: NUM_CS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      we_q   <= '0;
    end else if (cfg_en) begin
      type_q <= type_d;
      we_q   <= we_d;
    end
  end

  // one segment register per chip-select
  for (genvar i = 0; i < NUM_CS; i++) begin : g_seg
    localparam logic [RAW-1:0] MY_OFS = SEG_OFS + RAW'(4 * i);
    logic        seg_en;
    logic [31:0] seg_d;

    always_comb begin
      seg_en = wr_en && (addr == MY_OFS);
      seg_d  = wdata & SEG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seg_q[i] <= '0;
      else if (seg_en) seg_q[i] <= seg_d;
    end

    assign seg_flat[i*32 +: 32] = seg_q[i];
  end

  // read mux
  always_comb begin
    cfg_word                    = '0;
    cfg_word[TW-1:0]            = type_q;
    cfg_word[WE_LSB +: NUM_CS]  = we_q;
    rdata = '0;
    if (addr == CFG_OFS) rdata = cfg_word;
    for (int i = 0; i < NUM_CS; i++) begin
      if (addr == SEG_OFS + RAW'(4 * i)) rdata = seg_q[i];
    end
  end

  assign we_bits = we_q;
endmodule

// File: rtl/fcs_window.sv
`timescale 1ns/1ps
module fcs_window
  import fcs_pkg::*;
#(
  parameter bit          FINE      = 1'b0,
  parameter logic [31:0] FINE_BASE = 32'h2000_0000
) (
  input  logic [31:0] seg,
  output win_t        win
);
  logic unused_bits;
  assign unused_bits = ^seg;

  if (FINE) begin : g_fine
    logic [AW:0] lo_ofs, hi_ofs;
    always_comb begin
      lo_ofs = (AW+1)'(seg[11:4]) << FINE_SH;
      hi_ofs = (AW+1)'({1'b0, seg[27:20]} + 9'd1) << FINE_SH;
      win.en = (seg[27:20] != 8'd0);
      win.lo = {1'b0, FINE_BASE} + lo_ofs;
      win.hi = {1'b0, FINE_BASE} + hi_ofs;
    end
  end else begin : g_coarse
    always_comb begin
      win.en = 1'b1;
      win.lo = (AW+1)'(seg[23:16]) << COARSE_SH;
      win.hi = (AW+1)'(seg[31:24]) << COARSE_SH;
    end
  end
endmodule

// File: rtl/fcs_pick.sv
`timescale 1ns/1ps
module fcs_pick #(
  parameter int unsigned N   = 3,
  parameter int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   hit,
  output logic           found,
  output logic [IDW-1:0] idx
);
  // scan downward so the lowest set bit is the last one assigned
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/fcs_addr_decode.sv
`timescale 1ns/1ps
module fcs_addr_decode
  import fcs_pkg::*;
#(
  parameter int unsigned NUM_CS    = 3,
  parameter bit          FINE      = 1'b0,
  parameter logic [31:0] FINE_BASE = 32'h2000_0000,
  localparam int unsigned CSW      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [31:0]     req_addr,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [CSW-1:0]  rsp_cs,
  output logic [31:0]     rsp_offset
);
  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q_n, rst_m} <= 2'b00;
    else        {rst_q_n, rst_m} <= {rst_m, 1'b1};
  end

  logic [NUM_CS*32-1:0] seg_flat;
  logic [NUM_CS-1:0]    cs_we;

  fcs_regs #(.NUM_CS(NUM_CS), .FINE(FINE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .seg_flat (seg_flat),
    .we_bits  (cs_we)
  );

  win_t              win [NUM_CS];
  logic [NUM_CS-1:0] hit;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_win
    fcs_window #(.FINE(FINE), .FINE_BASE(FINE_BASE)) u_win (
      .seg (seg_flat[i*32 +: 32]),
      .win (win[i])
    );
    assign hit[i] = win[i].en &&
                    ({1'b0, req_addr} >= win[i].lo) &&
                    ({1'b0, req_addr} <  win[i].hi);
  end

  logic           found;
  logic [CSW-1:0] pick_idx;

  fcs_pick #(.N(NUM_CS), .IDW(CSW)) u_pick (
    .hit   (hit),
    .found (found),
    .idx   (pick_idx)
  );

  // next-state
  logic [31:0]    lo_sel;
  logic           we_sel;
  logic           v_d, err_d;
  logic [CSW-1:0] cs_d;
  logic [31:0]    off_d;

  always_comb begin
    lo_sel = '0;
    we_sel = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (pick_idx == CSW'(i)) begin
        lo_sel = win[i].lo[AW-1:0];
        we_sel = cs_we[i];
      end
    end
    v_d   = req_valid;
    err_d = req_valid && (!found || (req_write && !we_sel));
    cs_d  = (req_valid && !err_d) ? pick_idx : '0;
    off_d = (req_valid && !err_d) ? (req_addr - lo_sel) : '0;
  end

  // response register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_cs     <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid  <= v_d;
      rsp_err    <= err_d;
      rsp_cs     <= cs_d;
      rsp_offset <= off_d;
    end
  end
endmodule

// File: rtl/fcs_addr_decode_chk.sv
`timescale 1ns/1ps
module fcs_addr_decode_chk #(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned CSW    = 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [CSW-1:0]    rsp_cs,
  input logic [31:0]       rsp_offset,
  input logic [NUM_CS-1:0] cs_we
);
  logic [(1<<CSW)-1:0] we_d;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) we_d <= '0;
    else          we_d <= (1<<CSW)'(cs_we);
  end

  // R10: response one cycle after request
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_valid) else $error("R10 response missing");
  a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !rsp_valid) else $error("R10 spurious response");
  // R7: error responses carry zero chip and offset
  a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && rsp_err) |-> (rsp_cs == '0 && rsp_offset == '0)) else $error("R7 error fields");
  // R1: idle outputs quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rsp_valid |-> (!rsp_err && rsp_cs == '0 && rsp_offset == '0)) else $error("R1 idle outputs");
  // R5: selected chip exists
  a_r5_cs_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && !rsp_err) |-> (32'(rsp_cs) < NUM_CS)) else $error("R5 chip index");
  // R8: granted writes need the permission bit
  a_r8_we_granted: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && !rsp_err && $past(req_write)) |-> we_d[rsp_cs]) else $error("R8 write granted");
endmodule

bind fcs_addr_decode fcs_addr_decode_chk #(.NUM_CS(NUM_CS), .CSW(CSW)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_cs     (rsp_cs),
  .rsp_offset (rsp_offset),
  .cs_we      (cs_we)
);

// File: tb/fcs_addr_decode_test.sv
`timescale 1ns/1ps
module fcs_addr_decode_test;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;

  logic [31:0] c_rd, f_rd, c_off, f_off;
  logic        c_v, c_err, f_v, f_err;
  logic [1:0]  c_cs;
  logic [2:0]  f_cs;

  always #2 clk = ~clk;

  fcs_addr_decode #(.NUM_CS(3), .FINE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(c_rd), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(c_v),
    .rsp_err(c_err), .rsp_cs(c_cs), .rsp_offset(c_off));

  fcs_addr_decode #(.NUM_CS(5), .FINE(1'b1), .FINE_BASE(BASE)) uut_fine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(f_rd), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(f_v),
    .rsp_err(f_err), .rsp_cs(f_cs), .rsp_offset(f_off));

  // reference model state
  logic [31:0] mseg_c [3];
  logic [31:0] mseg_f [5];
  logic [31:0] mcfg_c = '0, mcfg_f = '0;
  bit          ec_v = 0, ec_err = 0, ef_v = 0, ef_err = 0;
  int          ec_cs = 0, ef_cs = 0;
  logic [31:0] ec_off = '0, ef_off = '0;
  string       cur_tag = "R1", exp_tag = "R1";
  int          n_cmp = 0, n_bad = 0;
  bit          started = 0;

  function automatic void ref_lookup(input bit fine, input logic [31:0] a, input bit wr,
                                     output bit err, output int cs, output logic [31:0] off);
    longint lo, hi, aa;
    logic [31:0] s, cfg;
    bit en;
    int n;
    err = 1; cs = 0; off = '0;
    n   = fine ? 5 : 3;
    cfg = fine ? mcfg_f : mcfg_c;
    aa  = longint'({32'd0, a});
    for (int i = 0; i < n; i++) begin
      if (fine) begin
        s  = mseg_f[i];
        en = (s[27:20] != 0);
        lo = longint'({32'd0, BASE}) + longint'(s[11:4]) * 1048576;
        hi = longint'({32'd0, BASE}) + (longint'(s[27:20]) + 1) * 1048576;
      end else begin
        s  = mseg_c[i];
        en = 1;
        lo = longint'(s[23:16]) * 8388608;
        hi = longint'(s[31:24]) * 8388608;
      end
      if (en && aa >= lo && aa < hi) begin
        if (!(wr && !cfg[16+i])) begin
          err = 0; cs = i; off = a - lo[31:0];
        end
        break;
      end
    end
  endfunction

  function automatic void ref_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h00) begin
      mcfg_c = d & 32'h0007_003F;
      mcfg_f = d & 32'h001F_03FF;
    end
    for (int i = 0; i < 3; i++) if (a == 8'h30 + 8'(4*i)) mseg_c[i] = d & 32'hFFFF_0000;
    for (int i = 0; i < 5; i++) if (a == 8'h30 + 8'(4*i)) mseg_f[i] = d & 32'h0FF0_0FF0;
  endfunction

  function automatic logic [31:0] ref_read(input bit fine, input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 8'h00) r = fine ? mcfg_f : mcfg_c;
    for (int i = 0; i < (fine ? 5 : 3); i++)
      if (a == 8'h30 + 8'(4*i)) r = fine ? mseg_f[i] : mseg_c[i];
    return r;
  endfunction

  // model advances on every rising edge
  always @(posedge clk) begin
    exp_tag = cur_tag;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) mseg_c[i] = '0;
      for (int i = 0; i < 5; i++) mseg_f[i] = '0;
      mcfg_c = '0; mcfg_f = '0;
      ec_v = 0; ec_err = 0; ec_cs = 0; ec_off = '0;
      ef_v = 0; ef_err = 0; ef_cs = 0; ef_off = '0;
    end else begin
      ec_v = req_valid; ef_v = req_valid;
      if (req_valid) begin
        ref_lookup(0, req_addr, req_write, ec_err, ec_cs, ec_off);
        ref_lookup(1, req_addr, req_write, ef_err, ef_cs, ef_off);
      end else begin
        ec_err = 0; ec_cs = 0; ec_off = '0;
        ef_err = 0; ef_cs = 0; ef_off = '0;
      end
      if (reg_wr) ref_write(reg_addr, reg_wdata);
    end
  end

  task automatic compare_one(input string who, input logic [87:0] act, input logic [87:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", exp_tag, who, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (started) begin
      compare_one("coarse",
        {7'd0, c_v, 7'd0, c_err, 8'(c_cs), c_off, c_rd},
        {7'd0, ec_v, 7'd0, ec_err, 8'(ec_cs), ec_off, ref_read(0, reg_addr)});
      compare_one("fine",
        {7'd0, f_v, 7'd0, f_err, 8'(f_cs), f_off, f_rd},
        {7'd0, ef_v, 7'd0, ef_err, 8'(ef_cs), ef_off, ref_read(1, reg_addr)});
    end
  end

  task automatic drive(input bit w, input logic [7:0] ra, input logic [31:0] wd,
                       input bit v, input bit rw, input logic [31:0] a);
    @(negedge clk); #1;
    reg_wr = w; reg_addr = ra; reg_wdata = wd;
    req_valid = v; req_write = rw; req_addr = a;
  endtask

  task automatic idle();                                  drive(0, 8'h00, '0, 0, 0, '0); endtask
  task automatic wr(input logic [7:0] ra, input logic [31:0] d); drive(1, ra, d, 0, 0, '0); endtask
  task automatic rd(input logic [7:0] ra);                drive(0, ra, '0, 0, 0, '0); endtask
  task automatic look(input logic [31:0] a, input bit rw); drive(0, 8'h00, '0, 1, rw, a); endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); started = 1;
    // R1: reset state
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();
    look(32'h0100_0000, 0); look(32'h2000_0000, 0);
    rd(8'h00); rd(8'h30); rd(8'h40); idle();

    // R9: register map, masks and unmapped offsets
    cur_tag = "R9";
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    wr(8'h00, 32'h0000_02AA); rd(8'h00);
    wr(8'h20, 32'hDEAD_BEEF); rd(8'h20);
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C); rd(8'h40);
    wr(8'h3C, 32'h0000_0000); rd(8'h3C);

    // R2: coarse window [0x0100_0000, 0x0200_0000)
    cur_tag = "R2";
    wr(8'h30, 32'h0402_0000); rd(8'h30);
    look(32'h0100_0000, 0); look(32'h01FF_FFFF, 0);
    // R7: misses at both edges
    cur_tag = "R7";
    look(32'h0200_0000, 0); look(32'h00FF_FFFF, 0); idle();

    // R3: fine window base+3 MB .. base+5 MB block inclusive
    cur_tag = "R3";
    wr(8'h34, 32'h0050_0030); rd(8'h34);
    look(32'h2030_0000, 0); look(32'h205F_FFFF, 0);
    look(32'h2060_0000, 0); look(32'h202F_FFFF, 0);

    // R4: zero end field disables the window
    cur_tag = "R4";
    wr(8'h38, 32'h0000_0010); look(32'h2010_0000, 0);
    wr(8'h38, 32'h0000_0000); look(32'h2000_0000, 0); idle();

    // R5: overlap, lowest index wins
    cur_tag = "R5";
    wr(8'h30, 32'h0800_0000); wr(8'h34, 32'h0602_0000);
    look(32'h0180_0000, 0); look(32'h2010_0000, 0);
    wr(8'h30, 32'h0000_0000);
    look(32'h0180_0000, 0); look(32'h2010_0000, 0);

    // R6: offsets inside the selected window
    cur_tag = "R6";
    look(32'h02AB_CDEF, 0); look(32'h205A_5A5A, 0); look(32'h0100_0001, 0);

    // R8: write permission
    cur_tag = "R8";
    look(32'h0180_0000, 1); look(32'h2010_0000, 1);
    wr(8'h00, 32'h001F_02AA);
    look(32'h0180_0000, 1); look(32'h2010_0000, 1);
    wr(8'h00, 32'h0001_02AA); wr(8'h30, 32'h0201_0000);
    look(32'h0180_0000, 1); look(32'h0180_0000, 0); look(32'h0080_0000, 1);

    // R10: back-to-back and gapped requests
    cur_tag = "R10";
    look(32'h0180_0000, 0); look(32'h0080_0000, 0); idle(); look(32'h2010_0000, 0); idle(); idle();

    // R11: write and lookup in the same cycle
    cur_tag = "R11";
    drive(1, 8'h38, 32'h0A08_0000, 1, 0, 32'h0450_0000);
    look(32'h0450_0000, 0);
    drive(1, 8'h3C, 32'h0070_0000, 1, 0, 32'h2000_0000);
    look(32'h2000_0000, 0); idle();

    // random sweep: R2, R3, R5, R6, R8 together
    cur_tag = "R6";
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [31:0] a;
      sel = $urandom % 8;
      a = (($urandom % 2) != 0 ? BASE : 32'h0) | ($urandom & 32'h0FFF_FFFF);
      if (sel == 0)      wr(8'h30 + 8'(4 * ($urandom % 5)), $urandom & 32'h1F1F_0FF0);
      else if (sel == 1) wr(8'h00, $urandom);
      else if (sel == 2) rd(8'h30 + 8'(4 * ($urandom % 6)));
      else               look(a, ($urandom % 2) != 0);
    end
    idle(); idle();
    finish_run();
  end
endmodule